// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Cache

This block keeps recently used logical-to-physical page translations close to the address path. The translations live in a table of 16 sets with two ways per set. A lookup splits the logical address into a page number and an in-page offset. The low bits of the page number pick a set. Both ways of that set compare their stored upper page bits with the request at the same time. The way that matches supplies its physical frame and access rights. The offset is not translated: it is appended to the frame to form the physical address.

After a miss, the page walker outside the block presents the translation it fetched on the refill port. The block chooses the destination way as follows:
- an entry that already holds the same page, if one exists;
- otherwise an empty way;
- otherwise the way that the set's least-recently-used bit names.

Because each set has two ways, two pages that share index bits can both stay resident. A loop that touches both pages therefore does not miss on every pass.

A flush input empties the whole table in one cycle. Results are registered, so a lookup returns one cycle after it is issued. A refill presented in the same cycle as a lookup of the same page is forwarded straight to the result.

Top module: `tlb_2way`

## Requirements
- R1: After reset, every entry is invalid, `res_valid_o` and `hit_o` are 0, and the first lookup of any page misses.
- R2: A lookup sampled at clock edge k drives `res_valid_o`=1 together with `hit_o`, `paddr_o` and `rights_o` after edge k. If no lookup is sampled at an edge, `res_valid_o` is 0 after that edge.
- R3: The logical address is split into a page number (bits [31:12]) and an offset (bits [11:0]). Page-number bits [3:0] select the set, and bits [19:4] are the tag. On a hit, `paddr_o[31:12]` is the cached frame and `rights_o` is the cached rights.
- R4: On a hit, `paddr_o[11:0]` equals the offset bits of the looked-up address.
- R5: Two pages with equal index bits and different tags stay resident together, and both hit.
- R6: Each set keeps a least-recently-used bit. A hit, or a refill, makes the other way of the set the next victim. A refill into a full set replaces that victim. An empty way is filled before any valid way is replaced.
- R7: A refill of a page that is already cached overwrites that entry in place. No other entry of the set is evicted.
- R8: A flush invalidates all entries in one cycle. A lookup in the flush cycle misses, and a refill in the flush cycle is discarded.
- R9: A refill and a lookup of the same page in the same cycle produce a hit that carries the refill's frame and rights.
- R10: Sets are independent: filling one set does not disturb entries in other sets.
- R11: A lookup of a page that is not cached returns `res_valid_o`=1 with `hit_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lookup_i | input | 1 | Lookup request strobe |
| lookup_vaddr_i | input | 32 | Logical address to translate |
| refill_i | input | 1 | Refill strobe from the page walker |
| refill_lpn_i | input | 20 | Logical page number of the refill |
| refill_ppn_i | input | 20 | Physical frame of the refill |
| refill_rights_i | input | 4 | Access rights of the refill |
| res_valid_o | output | 1 | Lookup result present this cycle |
| hit_o | output | 1 | Translation found |
| paddr_o | output | 32 | Physical address (frame and offset) |
| rights_o | output | 4 | Access rights of the hit entry |

## Verification
The replacement bit cannot be read at the ports, so an error in it shows up only when a third page is refilled into a full set. The wrong neighbour is then evicted, and the next lookup of the page that should have survived reports a miss. The bench therefore follows every replacement with lookups of all pages in the set. A corrupted tag or frame, or a lost valid bit, shows up on the first lookup after the refill, one cycle after that lookup is issued. A missing forward or a flush that does not take effect is visible on the very next result.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned NUM_WAYS = 2;

  // destination way for a refill: same page, then empty way, then LRU victim
  function automatic logic pick_victim(input logic [1:0] match,
                                       input logic [1:0] valid,
                                       input logic       lru);
    if (match[0])       return 1'b0;
    else if (match[1])  return 1'b1;
    else if (!valid[0]) return 1'b0;
    else if (!valid[1]) return 1'b1;
    else                return lru;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int unsigned SET_W    = 4,
  parameter int unsigned TAG_W    = 16,
  parameter int unsigned PPN_W    = 20,
  parameter int unsigned RIGHTS_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                we_i,
  input  logic [SET_W-1:0]    wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic [PPN_W-1:0]    wr_ppn_i,
  input  logic [RIGHTS_W-1:0] wr_rights_i,
  input  logic [SET_W-1:0]    lk_idx_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  input  logic [SET_W-1:0]    rf_idx_i,
  input  logic [TAG_W-1:0]    rf_tag_i,
  output logic                lk_hit_o,
  output logic [PPN_W-1:0]    lk_ppn_o,
  output logic [RIGHTS_W-1:0] lk_rights_o,
  output logic                rf_valid_o,
  output logic                rf_match_o
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]     valid_q;
  logic [TAG_W-1:0]    tag_q    [SETS];
  logic [PPN_W-1:0]    ppn_q    [SETS];
  logic [RIGHTS_W-1:0] rights_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (we_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i && !flush_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      ppn_q[wr_idx_i]    <= wr_ppn_i;
      rights_q[wr_idx_i] <= wr_rights_i;
    end
  end

  assign lk_hit_o    = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_ppn_o    = ppn_q[lk_idx_i];
  assign lk_rights_o = rights_q[lk_idx_i];
  assign rf_valid_o  = valid_q[rf_idx_i];
  assign rf_match_o  = valid_q[rf_idx_i] && (tag_q[rf_idx_i] == rf_tag_i);

  // R8
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (valid_q == '0));

  // R3
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && !flush_i) |-> valid_q[$past(wr_idx_i)]);
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned SET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_idx_i,
  input  logic             touch_way_i,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_idx_i,
  input  logic             fill_way_i,
  input  logic [SET_W-1:0] rd_idx_i,
  output logic             rd_lru_o
);
  localparam int unsigned SETS = 1 << SET_W;

  // bit names the way to replace next
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lru_q <= '0;
    else if (flush_i) lru_q <= '0;
    else begin
      if (touch_i) lru_q[touch_idx_i] <= ~touch_way_i;
      if (fill_i)  lru_q[fill_idx_i]  <= ~fill_way_i;
    end
  end

  assign rd_lru_o = lru_q[rd_idx_i];

  // R6
  fill_lru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fill_i && !flush_i) |-> (lru_q[$past(fill_idx_i)] != $past(fill_way_i)));

  // R6
  touch_lru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(touch_i && !fill_i && !flush_i) |->
      (lru_q[$past(touch_idx_i)] != $past(touch_way_i)));
endmodule

// File: rtl/tlb_2way.sv
module tlb_2way
  import tlb_pkg::*;
#(
  parameter int unsigned LPN_W    = 20,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PPN_W    = 20,
  parameter int unsigned RIGHTS_W = 4,
  parameter int unsigned SET_W    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic                   lookup_i,
  input  logic [LPN_W+OFF_W-1:0] lookup_vaddr_i,
  input  logic                   refill_i,
  input  logic [LPN_W-1:0]       refill_lpn_i,
  input  logic [PPN_W-1:0]       refill_ppn_i,
  input  logic [RIGHTS_W-1:0]    refill_rights_i,
  output logic                   res_valid_o,
  output logic                   hit_o,
  output logic [PPN_W+OFF_W-1:0] paddr_o,
  output logic [RIGHTS_W-1:0]    rights_o
);
  localparam int unsigned TAG_W = LPN_W - SET_W;
  localparam int unsigned VA_W  = LPN_W + OFF_W;

  logic [LPN_W-1:0] lk_lpn;
  logic [OFF_W-1:0] lk_off;
  logic [SET_W-1:0] lk_idx, rf_idx;
  logic [TAG_W-1:0] lk_tag, rf_tag;

  assign lk_lpn = lookup_vaddr_i[VA_W-1:OFF_W];
  assign lk_off = lookup_vaddr_i[OFF_W-1:0];
  assign lk_idx = lk_lpn[SET_W-1:0];
  assign lk_tag = lk_lpn[LPN_W-1:SET_W];
  assign rf_idx = refill_lpn_i[SET_W-1:0];
  assign rf_tag = refill_lpn_i[LPN_W-1:SET_W];

  logic [NUM_WAYS-1:0] way_hit, rf_valid, rf_match, way_we;
  logic [PPN_W-1:0]    way_ppn    [NUM_WAYS];
  logic [RIGHTS_W-1:0] way_rights [NUM_WAYS];
  logic                lru_bit, victim, fill_en;

  assign fill_en = refill_i && !flush_i;
  assign victim  = pick_victim(rf_match, rf_valid, lru_bit);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_we[w] = fill_en && (victim == w[0]);
    tlb_way #(
      .SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)
    ) u_way (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush_i),
      .we_i        (way_we[w]),
      .wr_idx_i    (rf_idx),
      .wr_tag_i    (rf_tag),
      .wr_ppn_i    (refill_ppn_i),
      .wr_rights_i (refill_rights_i),
      .lk_idx_i    (lk_idx),
      .lk_tag_i    (lk_tag),
      .rf_idx_i    (rf_idx),
      .rf_tag_i    (rf_tag),
      .lk_hit_o    (way_hit[w]),
      .lk_ppn_o    (way_ppn[w]),
      .lk_rights_o (way_rights[w]),
      .rf_valid_o  (rf_valid[w]),
      .rf_match_o  (rf_match[w])
    );
  end

  // same-cycle refill of the looked-up page bypasses the arrays
  logic fwd, any_hit, touch;
  logic [PPN_W-1:0]    sel_ppn;
  logic [RIGHTS_W-1:0] sel_rights;

  assign fwd     = lookup_i && refill_i && (lk_lpn == refill_lpn_i);
  assign any_hit = fwd || (|way_hit);
  assign touch   = lookup_i && !flush_i && !fwd && (|way_hit);

  always_comb begin
    if (fwd) begin
      sel_ppn    = refill_ppn_i;
      sel_rights = refill_rights_i;
    end else if (way_hit[1]) begin
      sel_ppn    = way_ppn[1];
      sel_rights = way_rights[1];
    end else begin
      sel_ppn    = way_ppn[0];
      sel_rights = way_rights[0];
    end
  end

  tlb_lru #(.SET_W(SET_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .touch_i     (touch),
    .touch_idx_i (lk_idx),
    .touch_way_i (way_hit[1]),
    .fill_i      (fill_en),
    .fill_idx_i  (rf_idx),
    .fill_way_i  (victim),
    .rd_idx_i    (rf_idx),
    .rd_lru_o    (lru_bit)
  );

  logic                res_valid_q, hit_q;
  logic [PPN_W-1:0]    ppn_q;
  logic [OFF_W-1:0]    off_q;
  logic [RIGHTS_W-1:0] rights_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      hit_q       <= 1'b0;
      ppn_q       <= '0;
      off_q       <= '0;
      rights_q    <= '0;
    end else begin
      res_valid_q <= lookup_i;
      hit_q       <= lookup_i && !flush_i && any_hit;
      if (lookup_i) begin
        ppn_q    <= sel_ppn;
        off_q    <= lk_off;
        rights_q <= sel_rights;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign hit_o       = hit_q;
  assign paddr_o     = {ppn_q, off_q};
  assign rights_o    = rights_q;

  // R5
  dup_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |-> $onehot0(way_hit));

  // R2
  hit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> res_valid_o);

  // R8
  flush_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> !hit_o);

  // R9
  fwd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fwd && !flush_i) |-> (hit_o && (paddr_o[PPN_W+OFF_W-1:OFF_W] == $past(refill_ppn_i))));
endmodule

// File: tb/tlb_2way_tb.sv
`timescale 1ns/1ps
module tlb_2way_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        lookup_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0;
  logic        refill_i = 1'b0;
  logic [19:0] refill_lpn_i = '0;
  logic [19:0] refill_ppn_i = '0;
  logic [3:0]  refill_rights_i = '0;
  logic        res_valid_o, hit_o;
  logic [31:0] paddr_o;
  logic [3:0]  rights_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tlb_2way u_dut (
    .clk_i, .rst_ni, .flush_i, .lookup_i, .lookup_vaddr_i,
    .refill_i, .refill_lpn_i, .refill_ppn_i, .refill_rights_i,
    .res_valid_o, .hit_o, .paddr_o, .rights_o
  );

  localparam logic [19:0] PG_A = 20'h12345, PG_B = 20'hABCD5, PG_C = 20'h00015,
                          PG_D = 20'h77775, PG_E = 20'h4A2C3, PG_F = 20'h9E0E3,
                          PG_S0 = 20'h55550, PG_S9 = 20'h01239, PG_SF = 20'hFEDCF;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_refill(input logic [19:0] lpn, input logic [19:0] ppn, input logic [3:0] rt);
    @(negedge clk_i);
    refill_i = 1'b1; refill_lpn_i = lpn; refill_ppn_i = ppn; refill_rights_i = rt;
    @(negedge clk_i);
    refill_i = 1'b0;
  endtask

  // result is registered: sample at the negedge after the capturing posedge
  task automatic do_lookup(input string req, input logic [19:0] lpn, input logic [11:0] off,
                           input logic exp_hit, input logic [19:0] ppn, input logic [3:0] rt);
    @(negedge clk_i);
    lookup_i = 1'b1; lookup_vaddr_i = {lpn, off};
    @(negedge clk_i);
    lookup_i = 1'b0;
    check(req, "res_valid", 64'(res_valid_o), 64'(1'b1));
    check(req, "hit", 64'(hit_o), 64'(exp_hit));
    if (exp_hit) begin
      check(req, "paddr", 64'(paddr_o), 64'({ppn, off}));
      check(req, "rights", 64'(rights_o), 64'(rt));
    end
  endtask

  task automatic t_reset();
    check("R1", "res_valid idle", 64'(res_valid_o), 64'(1'b0));
    check("R1", "hit idle", 64'(hit_o), 64'(1'b0));
    do_lookup("R1", PG_A, 12'h000, 1'b0, '0, '0);
    do_lookup("R11", PG_B, 12'h123, 1'b0, '0, '0);
  endtask

  task automatic t_single();
    do_refill(PG_A, 20'h00A01, 4'h5);
    do_lookup("R3", PG_A, 12'hABC, 1'b1, 20'h00A01, 4'h5);
    check("R4", "offset", 64'(paddr_o[11:0]), 64'(12'hABC));
    @(negedge clk_i);
    check("R2", "res_valid drops", 64'(res_valid_o), 64'(1'b0));
  endtask

  task automatic t_coexist();
    do_refill(PG_B, 20'h00B02, 4'h6);
    do_lookup("R5", PG_A, 12'h010, 1'b1, 20'h00A01, 4'h5);
    do_lookup("R5", PG_B, 12'h020, 1'b1, 20'h00B02, 4'h6);
    do_lookup("R5", PG_A, 12'h030, 1'b1, 20'h00A01, 4'h5);
  endtask

  task automatic t_lru();
    // A used last: C replaces B
    do_refill(PG_C, 20'h00C03, 4'h7);
    do_lookup("R6", PG_A, 12'h001, 1'b1, 20'h00A01, 4'h5);
    do_lookup("R6", PG_C, 12'h002, 1'b1, 20'h00C03, 4'h7);
    do_lookup("R6", PG_B, 12'h003, 1'b0, '0, '0);
    // C used last: D replaces A
    do_refill(PG_D, 20'h00D04, 4'h8);
    do_lookup("R6", PG_A, 12'h004, 1'b0, '0, '0);
    do_lookup("R6", PG_D, 12'h005, 1'b1, 20'h00D04, 4'h8);
    do_lookup("R6", PG_C, 12'h006, 1'b1, 20'h00C03, 4'h7);
  endtask

  task automatic t_update();
    // victim bit names D's way; refreshing C must not evict D
    do_refill(PG_C, 20'h00C99, 4'h9);
    do_lookup("R7", PG_D, 12'h007, 1'b1, 20'h00D04, 4'h8);
    do_lookup("R7", PG_C, 12'h008, 1'b1, 20'h00C99, 4'h9);
  endtask

  task automatic t_sets();
    do_refill(PG_S0, 20'h10000, 4'h1);
    do_refill(PG_S9, 20'h10009, 4'h2);
    do_refill(PG_SF, 20'h1000F, 4'h3);
    do_lookup("R10", PG_S0, 12'hFFF, 1'b1, 20'h10000, 4'h1);
    do_lookup("R10", PG_S9, 12'h800, 1'b1, 20'h10009, 4'h2);
    do_lookup("R10", PG_SF, 12'h001, 1'b1, 20'h1000F, 4'h3);
    do_lookup("R10", PG_D, 12'h00A, 1'b1, 20'h00D04, 4'h8);
  endtask

  task automatic t_fwd();
    @(negedge clk_i);
    refill_i = 1'b1; refill_lpn_i = PG_E; refill_ppn_i = 20'h0E0E0; refill_rights_i = 4'hC;
    lookup_i = 1'b1; lookup_vaddr_i = {PG_E, 12'h5A5};
    @(negedge clk_i);
    refill_i = 1'b0; lookup_i = 1'b0;
    check("R9", "fwd hit", 64'(hit_o), 64'(1'b1));
    check("R9", "fwd paddr", 64'(paddr_o), 64'({20'h0E0E0, 12'h5A5}));
    check("R9", "fwd rights", 64'(rights_o), 64'(4'hC));
    do_lookup("R9", PG_E, 12'h0F0, 1'b1, 20'h0E0E0, 4'hC);
  endtask

  task automatic t_flush();
    @(negedge clk_i);
    flush_i = 1'b1; lookup_i = 1'b1; lookup_vaddr_i = {PG_D, 12'h000};
    refill_i = 1'b1; refill_lpn_i = PG_F; refill_ppn_i = 20'h0F0F0; refill_rights_i = 4'hF;
    @(negedge clk_i);
    flush_i = 1'b0; lookup_i = 1'b0; refill_i = 1'b0;
    check("R8", "lookup in flush cycle res_valid", 64'(res_valid_o), 64'(1'b1));
    check("R8", "lookup in flush cycle hit", 64'(hit_o), 64'(1'b0));
    do_lookup("R8", PG_D, 12'h000, 1'b0, '0, '0);
    do_lookup("R8", PG_E, 12'h000, 1'b0, '0, '0);
    do_lookup("R8", PG_S9, 12'h000, 1'b0, '0, '0);
    do_lookup("R8", PG_F, 12'h000, 1'b0, '0, '0);
    do_refill(PG_A, 20'h00A55, 4'h4);
    do_lookup("R8", PG_A, 12'h321, 1'b1, 20'h00A55, 4'h4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_coexist();
    t_lru();
    t_update();
    t_sets();
    t_fwd();
    t_flush();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule